// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Priority Controller

This block chooses which of thirteen interrupt sources the CPU should service next. Each source has an enable bit. Twelve of the sources can be placed at a high or a low software level. The power-fail source sits on a fixed third level above both software levels. When two requests share a level, a fixed natural order decides between them, and the older classic sources come ahead of the newer ones. The block presents the winner to the CPU as a request line, an 8-bit vector address and the winner's level.

The controller also tracks nested service. It keeps one bit for each level that is currently in service. A request can interrupt a running handler only when that handler runs at a strictly lower level. The CPU acknowledges a request, which marks the winner's level as active. The CPU signals a return from interrupt, which clears the highest active level. A request that has been presented holds its vector and level steady until the CPU acknowledges it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_req` is 0 and `act_lvl` is 3'b000.
- R2: Source 0 (power-fail) requests at level 2 with vector 33h. Its own enable bit gates it, but `glob_en` does not mask it. It outranks every other source.
- R3: Sources 1 to 12 request at level 1 when `hi_pri[s-1]` is 1 and at level 0 otherwise. A higher level beats any lower one, whatever the source index.
- R4: Within one level, the pending source with the lowest index wins.
- R5: The vector for source 0..12 is, in order: 33h, 03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 3Bh, 43h, 4Bh, 53h, 5Bh, 63h.
- R6: Source 5 requests when `flag_in[5]` or `ser_tx_in[0]` is set. Source 7 requests when `flag_in[7]` or `ser_tx_in[1]` is set.
- R7: A source requests only while its bit in `src_en` is 1. With `glob_en` at 0, sources 1 to 12 raise no request.
- R8: A request is presented only when no level at or above its own is active in `act_lvl`. Requests at an equal or lower level wait until a return.
- R9: While `irq_req` is 1 and `cpu_ack` is 0, `irq_req`, `irq_vec` and `irq_lvl` stay unchanged on the next cycle, even if the source inputs change.
- R10: When `cpu_ack` arrives with `irq_req` at 1, the next cycle sets bit `irq_lvl` of `act_lvl` and drops `irq_req`. A `cpu_ack` that arrives while `irq_req` is 0 changes nothing.
- R11: A `cpu_reti` pulse clears the highest set bit of `act_lvl`.
- R12: The outputs are registered. A qualifying request shows on `irq_req` one clock after it is present at the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_in | input | 13 | Request flags by source index. Bits 5 and 7 carry the receive flags of serial ports 0 and 1 |
| ser_tx_in | input | 2 | Transmit flags of serial ports 0 and 1 |
| src_en | input | 13 | Enable bit per source |
| hi_pri | input | 12 | High-level select; bit s-1 belongs to source s |
| glob_en | input | 1 | Global enable for sources 1 to 12 |
| cpu_ack | input | 1 | CPU accepts the presented vector |
| cpu_reti | input | 1 | CPU returns from the current handler |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 8 | Vector address of the presented request |
| irq_lvl | output | 2 | Level of the presented request (0 low, 1 high, 2 power-fail) |
| act_lvl | output | 3 | Active-service bit per level |

## Verification
Faults in the active-level set appear at the ports in two ways. A bit that is wrongly set blocks every later request at or below that level, so `irq_req` stays low when it should rise. A bit that is wrongly cleared lets an equal-level request through one cycle later. The tests therefore nest services three deep and unwind them one return at a time, checking `act_lvl` and the request line after every step. A broken hold on the presented request shows as a changed `irq_vec` one cycle after the source inputs move. A wrong tie order or a wrong vector slot shows in the first cycle after a pair of requests is applied.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int NSRC     = 13;
    localparam int IDX_W    = $clog2(NSRC);
    localparam int NLVL     = 3;
    localparam int LVL_W    = $clog2(NLVL);
    localparam int VEC_W    = 8;
    localparam int PF_IDX   = 0;
    localparam int SER0_IDX = 5;
    localparam int SER1_IDX = 7;
    localparam int NSER     = 2;
    localparam logic [LVL_W-1:0] LVL_LO = LVL_W'(0);
    localparam logic [LVL_W-1:0] LVL_HI = LVL_W'(1);
    localparam logic [LVL_W-1:0] LVL_PF = LVL_W'(2);
    localparam logic [VEC_W-1:0] VEC_BASE = 8'h03;
    localparam int VEC_STEP = 8;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [NLVL-1:0]  lvl_set_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        lvl_t             lvl;
    } win_t;

    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
        lvl_t             lvl;
    } pend_t;

    // Vector slot: sources 1..6 take slots 0..5, the power-fail source takes
    // slot 6, sources 7..12 keep their own index as slot.
    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        int slot;
        if (int'(idx) == PF_IDX)       slot = 6;
        else if (int'(idx) < SER1_IDX) slot = int'(idx) - 1;
        else                           slot = int'(idx);
        return VEC_BASE + VEC_W'(slot * VEC_STEP);
    endfunction

    // Bit mask of the highest set level in a level set.
    function automatic lvl_set_t top_bit(input lvl_set_t s);
        lvl_set_t r;
        r = '0;
        for (int l = 0; l < NLVL; l++)
            if (s[l]) r = lvl_set_t'(1) << l;
        return r;
    endfunction
endpackage

// File: rtl/ipc_req_qualify.sv
module ipc_req_qualify
    import ipc_pkg::*;
(
    input  logic [NSRC-1:0]             flag_in,
    input  logic [NSER-1:0]             ser_tx_in,
    input  logic [NSRC-1:0]             src_en,
    input  logic [NSRC-2:0]             hi_pri,
    input  logic                        glob_en,
    output logic [NSRC-1:0]             req,
    output logic [NSRC-1:0][LVL_W-1:0]  src_lvl
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic raw;
        if (i == SER0_IDX) begin : g_s0
            assign raw = flag_in[i] | ser_tx_in[0];
        end else if (i == SER1_IDX) begin : g_s1
            assign raw = flag_in[i] | ser_tx_in[1];
        end else begin : g_plain
            assign raw = flag_in[i];
        end

        if (i == PF_IDX) begin : g_pf
            assign req[i]     = raw & src_en[i];
            assign src_lvl[i] = LVL_PF;
        end else begin : g_sw
            assign req[i]     = raw & src_en[i] & glob_en;
            assign src_lvl[i] = hi_pri[i-1] ? LVL_HI : LVL_LO;
        end
    end
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
    import ipc_pkg::*;
(
    input  logic [NSRC-1:0]            req,
    input  logic [NSRC-1:0][LVL_W-1:0] src_lvl,
    output win_t                       win
);
    logic [NLVL-1:0]            lvl_any;
    logic [NLVL-1:0][IDX_W-1:0] lvl_idx;

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        logic [NSRC-1:0] mask;
        for (genvar i = 0; i < NSRC; i++) begin : g_m
            assign mask[i] = req[i] && (src_lvl[i] == LVL_W'(l));
        end
        always_comb begin
            lvl_idx[l] = '0;
            for (int i = NSRC - 1; i >= 0; i--)
                if (mask[i]) lvl_idx[l] = IDX_W'(i);
        end
        assign lvl_any[l] = |mask;
    end

    always_comb begin
        win = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (lvl_any[l]) begin
                win.valid = 1'b1;
                win.idx   = lvl_idx[l];
                win.lvl   = LVL_W'(l);
            end
        end
    end
endmodule

// File: rtl/ipc_level_stack.sv
module ipc_level_stack
    import ipc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  lvl_t     push_lvl,
    input  logic     pop,
    input  lvl_t     probe_lvl,
    output logic     probe_ok,
    output lvl_set_t act
);
    lvl_set_t act_nxt;

    always_comb begin
        act_nxt = act;
        if (pop)  act_nxt = act_nxt & ~top_bit(act);
        if (push) act_nxt = act_nxt | (lvl_set_t'(1) << push_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) act <= '0;
        else     act <= act_nxt;
    end

    assign probe_ok = ((act >> probe_lvl) == '0);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import ipc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   flag_in,
    input  logic [NSER-1:0]   ser_tx_in,
    input  logic [NSRC-1:0]   src_en,
    input  logic [NSRC-2:0]   hi_pri,
    input  logic              glob_en,
    input  logic              cpu_ack,
    input  logic              cpu_reti,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [LVL_W-1:0]  irq_lvl,
    output logic [NLVL-1:0]   act_lvl
);
    logic [NSRC-1:0]            q_req;
    logic [NSRC-1:0][LVL_W-1:0] q_lvl;
    win_t                       win;
    logic                       may_take;
    pend_t                      pend;

    ipc_req_qualify u_qual (
        .flag_in   (flag_in),
        .ser_tx_in (ser_tx_in),
        .src_en    (src_en),
        .hi_pri    (hi_pri),
        .glob_en   (glob_en),
        .req       (q_req),
        .src_lvl   (q_lvl)
    );

    ipc_arbiter u_arb (
        .req     (q_req),
        .src_lvl (q_lvl),
        .win     (win)
    );

    ipc_level_stack u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (pend.req & cpu_ack),
        .push_lvl  (pend.lvl),
        .pop       (cpu_reti),
        .probe_lvl (win.lvl),
        .probe_ok  (may_take),
        .act       (act_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (!pend.req) begin
            if (win.valid && may_take) begin
                pend.req <= 1'b1;
                pend.vec <= vec_of(win.idx);
                pend.lvl <= win.lvl;
            end
        end else if (cpu_ack) begin
            pend.req <= 1'b0;
        end
    end

    assign irq_req = pend.req;
    assign irq_vec = pend.vec;
    assign irq_lvl = pend.lvl;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import ipc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cpu_ack,
    input logic             cpu_reti,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic [LVL_W-1:0] irq_lvl,
    input logic [NLVL-1:0]  act_lvl
);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !cpu_ack) |=> (irq_req && $stable(irq_vec) && $stable(irq_lvl)));

    p_strict_above_r8: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((act_lvl >> irq_lvl) == '0));

    p_ack_push_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_req && cpu_ack && !cpu_reti) |=>
            (!irq_req && act_lvl == ($past(act_lvl) | (3'b001 << $past(irq_lvl)))));

    p_ack_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && cpu_ack && !cpu_reti) |=> (act_lvl == $past(act_lvl)));

    p_reti_pop_r11: assert property (@(posedge clk) disable iff (rst)
        (cpu_reti && !cpu_ack && act_lvl != '0) |=>
            ($countones(act_lvl) + 1 == $countones($past(act_lvl))));

    p_pf_vec_r2: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_lvl == LVL_PF) |-> (irq_vec == 8'h33));

    p_lvl_legal_r3: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_lvl != 2'd3));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_ack  (cpu_ack),
    .cpu_reti (cpu_reti),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .irq_lvl  (irq_lvl),
    .act_lvl  (act_lvl)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] flag_in;
    logic [1:0]  ser_tx_in;
    logic [12:0] src_en;
    logic [11:0] hi_pri;
    logic        glob_en;
    logic        cpu_ack;
    logic        cpu_reti;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic [1:0]  irq_lvl;
    logic [2:0]  act_lvl;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_vec [13];

    always #4 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst(rst), .flag_in(flag_in), .ser_tx_in(ser_tx_in),
        .src_en(src_en), .hi_pri(hi_pri), .glob_en(glob_en),
        .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_lvl(irq_lvl), .act_lvl(act_lvl)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; flag_in = '0; ser_tx_in = '0; src_en = '0; hi_pri = '0;
        glob_en = 1'b0; cpu_ack = 1'b0; cpu_reti = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic ack_it();
        cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
    endtask

    task automatic reti_it();
        cpu_reti = 1'b1; step(); cpu_reti = 1'b0;
    endtask

    task automatic expect_req(input string tag, input int vec, input int lvl);
        chk({tag, " req"}, int'(irq_req), 1);
        chk({tag, " vec"}, int'(irq_vec), vec);
        chk({tag, " lvl"}, int'(irq_lvl), lvl);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 req after reset", int'(irq_req), 0);
        chk("R1 act after reset", int'(act_lvl), 0);
    endtask

    task automatic t_vectors();
        do_reset();
        glob_en = 1'b1;
        for (int i = 0; i < 13; i++) begin
            src_en = 13'd1 << i; flag_in = 13'd1 << i;
            step();
            expect_req("R5 R12 vector slot", int'(exp_vec[i]), (i == 0) ? 2 : 0);
            ack_it();
            chk("R10 ack sets level", int'(act_lvl), (i == 0) ? 4 : 1);
            flag_in = '0;
            reti_it();
            chk("R11 return clears", int'(act_lvl), 0);
        end
    endtask

    task automatic t_tie();
        do_reset();
        glob_en = 1'b1; src_en = '1;
        flag_in = (13'd1 << 3) | (13'd1 << 9);
        step();
        expect_req("R4 lowest index wins", 8'h13, 0);
        do_reset();
        glob_en = 1'b1; src_en = '1; hi_pri[8] = 1'b1;
        flag_in = (13'd1 << 3) | (13'd1 << 9);
        step();
        expect_req("R3 high level beats index", 8'h4B, 1);
    endtask

    task automatic t_mask();
        do_reset();
        src_en = '1; flag_in[3] = 1'b1;
        step(); step();
        chk("R7 global mask", int'(irq_req), 0);
        flag_in[0] = 1'b1; hi_pri = '1;
        step();
        expect_req("R2 power-fail unmasked", 8'h33, 2);
        ack_it();
        flag_in[0] = 1'b0; glob_en = 1'b1;
        step();
        chk("R8 blocked under power-fail", int'(irq_req), 0);
        reti_it(); step();
        expect_req("R8 after return", 8'h13, 1);
        do_reset();
        glob_en = 1'b1; flag_in[9] = 1'b1; flag_in[12] = 1'b1;
        step(); step();
        chk("R7 own enable off", int'(irq_req), 0);
        src_en[12] = 1'b1;
        step();
        expect_req("R7 watchdog enabled", 8'h63, 0);
        ack_it(); flag_in[12] = 1'b0; reti_it();
        src_en[9] = 1'b1;
        step();
        expect_req("R7 source enabled", 8'h4B, 0);
    endtask

    task automatic t_serial();
        do_reset();
        glob_en = 1'b1; src_en = '1; ser_tx_in[1] = 1'b1;
        step();
        expect_req("R6 serial1 transmit", 8'h3B, 0);
        ack_it(); ser_tx_in = '0; reti_it();
        ser_tx_in[0] = 1'b1;
        step();
        expect_req("R6 serial0 transmit", 8'h23, 0);
    endtask

    task automatic t_nest();
        do_reset();
        glob_en = 1'b1; src_en = '1; hi_pri[1] = 1'b1; hi_pri[5] = 1'b1;
        flag_in[4] = 1'b1; step();
        expect_req("R8 low first", 8'h1B, 0);
        ack_it(); flag_in[4] = 1'b0;
        chk("R10 act low", int'(act_lvl), 1);
        flag_in[2] = 1'b1; step();
        expect_req("R8 high preempts low", 8'h0B, 1);
        ack_it(); flag_in[2] = 1'b0;
        chk("R10 act high", int'(act_lvl), 3);
        flag_in[6] = 1'b1; flag_in[1] = 1'b1;
        step(); step();
        chk("R8 equal waits", int'(irq_req), 0);
        flag_in[0] = 1'b1; step();
        expect_req("R8 power-fail preempts", 8'h33, 2);
        ack_it(); flag_in[0] = 1'b0;
        chk("R10 act all", int'(act_lvl), 7);
        reti_it();
        chk("R11 pop power-fail", int'(act_lvl), 3);
        step();
        chk("R8 still equal", int'(irq_req), 0);
        reti_it();
        chk("R11 pop high", int'(act_lvl), 1);
        step();
        expect_req("R8 high after pop", 8'h2B, 1);
        ack_it(); flag_in[6] = 1'b0; reti_it();
        step();
        chk("R8 low equal waits", int'(irq_req), 0);
        reti_it();
        chk("R11 pop low", int'(act_lvl), 0);
        step();
        expect_req("R8 low after empty", 8'h03, 0);
    endtask

    task automatic t_hold();
        do_reset();
        glob_en = 1'b1; src_en = '1;
        flag_in[8] = 1'b1; step();
        expect_req("R9 first", 8'h43, 0);
        flag_in[1] = 1'b1; hi_pri[0] = 1'b1; step();
        expect_req("R9 held over better source", 8'h43, 0);
        flag_in[8] = 1'b0; step();
        expect_req("R9 held after withdrawal", 8'h43, 0);
        ack_it();
        chk("R10 drop on ack", int'(irq_req), 0);
        chk("R10 act after ack", int'(act_lvl), 1);
        step();
        expect_req("R9 next winner", 8'h03, 1);
        do_reset();
        ack_it(); step();
        chk("R10 idle ack act", int'(act_lvl), 0);
        chk("R10 idle ack req", int'(irq_req), 0);
    endtask

    initial begin
        exp_vec[0] = 8'h33; exp_vec[1] = 8'h03; exp_vec[2] = 8'h0B;
        exp_vec[3] = 8'h13; exp_vec[4] = 8'h1B; exp_vec[5] = 8'h23;
        exp_vec[6] = 8'h2B; exp_vec[7] = 8'h3B; exp_vec[8] = 8'h43;
        exp_vec[9] = 8'h4B; exp_vec[10] = 8'h53; exp_vec[11] = 8'h5B;
        exp_vec[12] = 8'h63;
        step();
        t_reset();
        t_vectors();
        t_tie();
        t_mask();
        t_serial();
        t_nest();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule